// File: doc/BRIEF.md
# Programmable Interrupt Controller Unit

This block collects 32 interrupt sources into two processor-facing request lines. Each source passes through a two-stage synchronizer. It is then qualified by a per-source polarity bit and detected as either level or edge, according to a per-source trigger bit. The result is held in a status register. The status register is gated by an enable register, and each enabled pending source is steered to the normal interrupt line or to the critical (machine-check style) line.

Software sees seven word registers on a single-cycle bus. Writes are taken on the clock edge while `bus_sel` and `bus_we` are high. Read data is a combinational function of `bus_addr`. Every register is readable, so software can change enable bits by read-modify-write. The vector register gives the lowest-numbered masked pending source directly, so the handler does not have to scan the masked-status word.

Register word addresses: 0 status (write-one-to-clear), 1 enable, 2 route, 3 polarity, 4 trigger, 5 vector (read-only), 6 masked status (read-only). Address 7 reads zero.

Top module: `picu_top`

## Requirements
- R1: After reset, status, enable and route read 0, polarity reads all ones, trigger reads 0, both interrupt outputs are low and the vector valid bit is 0.
- R2: Source n (input `irq_src[n]`) occupies bit 31-n of the status, enable, route, polarity, trigger and masked-status registers.
- R3: A change on `irq_src` reaches the status register on the third rising clock edge after it is applied, and not on an earlier edge.
- R4: A polarity bit of 1 makes the source active when its input is high; a polarity bit of 0 makes it active when its input is low.
- R5: With a trigger bit of 0 (level), the status bit follows the qualified input every cycle, and a write of one to it does not leave it cleared while the input is still active.
- R6: With a trigger bit of 1 (edge), the status bit sets when the qualified input goes from inactive to active, and it stays set after the input goes inactive.
- R7: Writing a 1 to a status bit clears an edge-mode bit. Writing a 0 leaves the bit unchanged, and writing all ones clears every edge-mode bit.
- R8: The masked-status register (address 6) reads status AND enable, and the enable register reads back exactly what was written.
- R9: `irq_norm` is high when any masked pending source has route bit 1. `irq_crit` is high when any masked pending source has route bit 0.
- R10: The vector register (address 5) holds a valid flag in bit 31 and, in bits 4:0, the index of the lowest-numbered masked pending source. With nothing pending it reads 0.
- R11: Writes to the vector and masked-status addresses have no effect, and address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 32 | Asynchronous interrupt sources, bit n is source n |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_norm | output | 1 | Normal interrupt request |
| irq_crit | output | 1 | Critical interrupt request |

## Verification
Random rounds draw a new polarity, trigger, route and enable word. They then apply two successive source patterns, so that level bits, edge bits with a rising transition, and edge bits with a falling or steady input all appear in the same word, with both polarities. A random partial clear then separates write-one-to-clear on edge bits from the level bits that re-assert. Directed cases pin the three-edge latency, the rule that the lowest-numbered source wins when several are pending, and the case where the two outputs differ only in the route bit. Further directed cases cover the read-only addresses and the unmapped address.

// File: rtl/picu_pkg.sv
package picu_pkg;
    localparam int NSRC     = 32;
    localparam int IDXW     = $clog2(NSRC);
    localparam int AW       = 3;
    localparam int SYNC_STG = 2;

    typedef enum logic [AW-1:0] {
        RA_STAT  = 3'd0,
        RA_EN    = 3'd1,
        RA_ROUTE = 3'd2,
        RA_POL   = 3'd3,
        RA_TRIG  = 3'd4,
        RA_VEC   = 3'd5,
        RA_MSK   = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] route;
        logic [NSRC-1:0] pol;
        logic [NSRC-1:0] trig;
    } cfg_t;

    // Source order <-> register order (source 0 at the MSB); self-inverse.
    function automatic logic [NSRC-1:0] flip(input logic [NSRC-1:0] v);
        logic [NSRC-1:0] r;
        for (int i = 0; i < NSRC; i++) r[NSRC-1-i] = v[i];
        return r;
    endfunction
endpackage

// File: rtl/picu_sync.sv
module picu_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         stg[s] <= '0;
                else if (s == 0) stg[s] <= d;
                else             stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/picu_status.sv
module picu_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sync_in,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] trig,
    input  logic [W-1:0] clr,
    output logic [W-1:0] stat
);
    logic [W-1:0] qual;
    logic [W-1:0] qual_d;
    logic [W-1:0] rise;

    assign qual = ~(sync_in ^ pol);
    assign rise = qual & ~qual_d;

    always_ff @(posedge clk) begin
        if (rst) qual_d <= '0;
        else     qual_d <= qual;
    end

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)          stat[i] <= 1'b0;
                else if (!trig[i]) stat[i] <= qual[i];
                else              stat[i] <= (stat[i] & ~clr[i]) | rise[i];
            end
        end
    endgenerate

    // R5: level-mode bits mirror the qualified input of the previous cycle
    a_r5_level_follows: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((stat & ~$past(trig)) == ($past(qual) & ~$past(trig))));

    // R6: an edge-mode bit that was set and not cleared stays set
    a_r6_edge_holds: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(stat) & $past(trig) & ~$past(clr) & ~stat) == '0));

    // R7: a cleared edge-mode bit with no new rise reads 0
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(clr) & $past(trig) & ~$past(rise) & stat) == '0));
endmodule

// File: rtl/picu_prio.sv
module picu_prio #(
    parameter int W    = 32,
    parameter int IDXW = 5
) (
    input  logic [W-1:0]    req,
    output logic            valid,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = W-1; i >= 0; i--) begin
            if (req[i]) idx = IDXW'(i);
        end
        valid = |req;
    end
endmodule

// File: rtl/picu_top.sv
module picu_top
    import picu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] irq_src,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    output logic            irq_norm,
    output logic            irq_crit
);
    localparam int PADW = NSRC - 1 - IDXW;

    cfg_t            cfg;
    logic [NSRC-1:0] src_s;
    logic [NSRC-1:0] stat;
    logic [NSRC-1:0] clr;
    logic [NSRC-1:0] masked;
    logic [NSRC-1:0] wsrc;
    logic            wr;
    logic            vec_valid;
    logic [IDXW-1:0] vec_idx;

    assign wr   = bus_sel & bus_we;
    assign wsrc = flip(bus_wdata);
    assign clr  = (wr && bus_addr == RA_STAT) ? wsrc : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.en    <= '0;
            cfg.route <= '0;
            cfg.pol   <= '1;
            cfg.trig  <= '0;
        end else if (wr) begin
            case (bus_addr)
                RA_EN:    cfg.en    <= wsrc;
                RA_ROUTE: cfg.route <= wsrc;
                RA_POL:   cfg.pol   <= wsrc;
                RA_TRIG:  cfg.trig  <= wsrc;
                default:  ;
            endcase
        end
    end

    picu_sync #(.W(NSRC), .STAGES(SYNC_STG)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_src),
        .q   (src_s)
    );

    picu_status #(.W(NSRC)) u_status (
        .clk     (clk),
        .rst     (rst),
        .sync_in (src_s),
        .pol     (cfg.pol),
        .trig    (cfg.trig),
        .clr     (clr),
        .stat    (stat)
    );

    assign masked = stat & cfg.en;

    picu_prio #(.W(NSRC), .IDXW(IDXW)) u_prio (
        .req   (masked),
        .valid (vec_valid),
        .idx   (vec_idx)
    );

    assign irq_norm = |(masked & cfg.route);
    assign irq_crit = |(masked & ~cfg.route);

    always_comb begin
        case (bus_addr)
            RA_STAT:  bus_rdata = flip(stat);
            RA_EN:    bus_rdata = flip(cfg.en);
            RA_ROUTE: bus_rdata = flip(cfg.route);
            RA_POL:   bus_rdata = flip(cfg.pol);
            RA_TRIG:  bus_rdata = flip(cfg.trig);
            RA_VEC:   bus_rdata = vec_valid ? {1'b1, {PADW{1'b0}}, vec_idx} : '0;
            RA_MSK:   bus_rdata = flip(masked);
            default:  bus_rdata = '0;
        endcase
    end

    // R10: the vector points at a source that is really pending
    a_r10_vec_pending: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> masked[vec_idx]);

    // R10: no lower-numbered pending source is skipped
    a_r10_vec_lowest: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> ((masked & ((NSRC'(1) << vec_idx) - NSRC'(1))) == '0));

    // R9: a request line is only raised for an enabled pending source
    a_r9_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (irq_norm | irq_crit) |-> vec_valid);

    // R8: enable only changes through a write to its address
    a_r8_enable_stable: assert property (@(posedge clk) disable iff (rst)
        !(wr && bus_addr == RA_EN) |=> $stable(cfg.en));
endmodule

// File: tb/picu_top_tb.sv
module picu_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_src = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_norm, irq_crit;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    picu_top dut_i (
        .clk(clk), .rst(rst), .irq_src(irq_src),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_norm(irq_norm), .irq_crit(irq_crit)
    );

    function automatic logic [31:0] rv(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[31-i] = v[i];
        return r;
    endfunction

    function automatic logic [31:0] exp_vec(input logic [31:0] m);
        for (int i = 0; i < 32; i++)
            if (m[i]) return {1'b1, 26'd0, 5'(i)};
        return 32'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic clks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Model state (source order)
    logic [31:0] m_en, m_rt, m_pol, m_trig, m_stat;

    task automatic check_all(input string tag);
        logic [31:0] d, msk;
        msk = m_stat & m_en;
        rd(3'd0, d); chk({tag, " R5 R6 status"}, d, rv(m_stat));
        rd(3'd6, d); chk({tag, " R8 masked"}, d, rv(msk));
        rd(3'd5, d); chk({tag, " R10 vector"}, d, exp_vec(msk));
        rd(3'd1, d); chk({tag, " R8 enable readback"}, d, rv(m_en));
        chk({tag, " R9 irq_norm"}, {31'd0, irq_norm}, {31'd0, |(msk & m_rt)});
        chk({tag, " R9 irq_crit"}, {31'd0, irq_crit}, {31'd0, |(msk & ~m_rt)});
    endtask

    initial begin
        logic [31:0] d, qa, qb, sa, sb, cm;
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, d); chk("R1 status", d, 32'd0);
        rd(3'd1, d); chk("R1 enable", d, 32'd0);
        rd(3'd2, d); chk("R1 route", d, 32'd0);
        rd(3'd3, d); chk("R1 polarity", d, 32'hffff_ffff);
        rd(3'd4, d); chk("R1 trigger", d, 32'd0);
        rd(3'd5, d); chk("R1 vector", d, 32'd0);
        chk("R1 outputs", {30'd0, irq_norm, irq_crit}, 32'd0);

        // R3 latency and R2 mapping: source 0 at MSB
        wr(3'd1, 32'hffff_ffff);
        irq_src = 32'h0000_0001;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(3'd0, d); chk("R3 not before third edge", d, 32'd0);
        @(posedge clk); @(negedge clk);
        rd(3'd0, d); chk("R3 R2 source0 at bit31", d, 32'h8000_0000);
        chk("R9 route0 to crit", {30'd0, irq_norm, irq_crit}, 32'd1);

        // R5: level bit cannot stay cleared
        wr(3'd0, 32'h8000_0000);
        rd(3'd0, d); chk("R5 level re-asserts", d, 32'h8000_0000);

        // R9: route bit 1 selects normal line
        wr(3'd2, 32'h8000_0000);
        chk("R9 route1 to norm", {30'd0, irq_norm, irq_crit}, 32'd2);

        // R10 priority: sources 5 and 20
        irq_src = (32'd1 << 5) | (32'd1 << 20);
        clks(4);
        rd(3'd5, d); chk("R10 lowest index wins", d, {1'b1, 26'd0, 5'd5});

        // R11: read-only addresses and unmapped address
        wr(3'd6, 32'h0);
        wr(3'd5, 32'h0);
        rd(3'd6, d); chk("R11 masked write ignored", d, rv((32'd1 << 5) | (32'd1 << 20)));
        rd(3'd1, d); chk("R11 enable untouched", d, 32'hffff_ffff);
        rd(3'd7, d); chk("R11 unmapped reads zero", d, 32'd0);

        // R4 directed: active-low source 3 with input low
        irq_src = '0;
        wr(3'd3, rv(~(32'd1 << 3)));
        clks(4);
        rd(3'd0, d); chk("R4 active low", d, rv(32'd1 << 3));
        wr(3'd3, 32'hffff_ffff);
        clks(4);

        // Random rounds: R4 R5 R6 R7 R8 R9 R10
        for (int r = 0; r < 60; r++) begin
            m_en = $urandom; m_rt = $urandom; m_pol = $urandom; m_trig = $urandom;
            if (r % 7 == 0) m_en = 32'hffff_ffff;
            wr(3'd1, rv(m_en));
            wr(3'd2, rv(m_rt));
            wr(3'd3, rv(m_pol));
            wr(3'd4, rv(m_trig));
            sa = $urandom;
            irq_src = sa;
            clks(4);
            wr(3'd0, 32'hffff_ffff);   // R7 clear all
            qa = ~(sa ^ m_pol);
            m_stat = qa & ~m_trig;
            check_all("R7 clear-all");
            sb = (r % 5 == 0) ? ~sa : $urandom;
            irq_src = sb;
            clks(4);
            qb = ~(sb ^ m_pol);
            m_stat = (qb & ~m_trig) | (m_trig & (m_stat | (qb & ~qa)));
            check_all("R4 R6 pattern");
            cm = $urandom;
            wr(3'd0, rv(cm));
            m_stat = (qb & ~m_trig) | (m_stat & m_trig & ~cm);
            check_all("R7 partial clear");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule